// File: doc/BRIEF.md
# Masked Window Comparator

This block qualifies one observed value per clock, such as a program counter or a bus address, against a programmable window. It first clears the bits of the value that a mask register leaves zero. It then tests whether the masked result lies between a lower bound and that bound plus a range, with both ends inclusive. The result is one trigger bit that a trigger matrix can combine with other event sources.

Software-side configuration arrives on a single write port. A two-bit selector picks the bound, the range, the mask or the control word. Bit 0 of the control word enables the comparator. While the comparator is disabled, the trigger output stays low. The window is held as a base plus an offset, so a range of zero turns the window into an exact-equality match on the bound. The sum of bound and range is formed one bit wider than the value, so a window near the top of the value space never wraps around to small values.

Top module: `winMatch`

## Requirements
- R1: Before any comparison the observed value is ANDed bit by bit with the mask register, so bits that are zero in the mask have no effect on the result.
- R2: The lower end is inclusive: a masked value equal to the bound matches, and a masked value one below the bound does not match.
- R3: The upper end is inclusive: a masked value equal to bound plus range matches, and a masked value one above it does not match.
- R4: With range 0, the output is high only when the masked value equals the bound exactly.
- R5: With mask 0x20E, bound 0x200 and range 0xF, masked values 0x200 through 0x20F match. For example, observed values 0x200, 0x20F, 0x300 and 0x1200 match, and 0x1F0 does not.
- R6: Bound plus range is computed one bit wider than the value. With bound 0xFFFFFFF0 and range 0x20, the value 0xFFFFFFFF matches, while 0x00000005 and 0xFFFFFFEF do not.
- R7: While the enable bit (bit 0 of the control word) is 0, the output is 0 for every observed value and every window setting.
- R8: With the registered-output option (the default), the output reflects the value presented one clock earlier. Reset drives the output to 0, and the mask resets to all ones, the bound and range to 0, and the enable bit to 0.
- R9: A configuration write on a clock edge is used from the next edge onward. The edge that captures the write still compares with the old setting.
- R10: The write selector codes are 0 for bound, 1 for range, 2 for mask and 3 for the control word. A write happens only on edges where the write strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: 0 bound, 1 range, 2 mask, 3 control |
| cfgData | input | W | Configuration write data |
| obsValue | input | W | Observed value to qualify |
| hit | output | 1 | Window match trigger |

## Verification
The checker keeps its own copy of the configuration, built from the write port. On every cycle it checks four things: the output stays low in and just after reset and while disabled, nothing below the bound or above bound plus range raises the output, an exact match with range zero always raises it, and any masked value inside the window raises it on the next edge. The bench's scenarios are the only place that shows which specific values match: the worked example with mask 0x20E, the behaviour at the top of the value space without wrap, that a write has no effect on the edge that captures it, and that the output does not change before an edge.

// File: rtl/winMatch_pkg.sv
package winMatch_pkg;

  typedef enum logic [1:0] {
    SEL_BOUND = 2'd0,
    SEL_RANGE = 2'd1,
    SEL_MASK  = 2'd2,
    SEL_CTRL  = 2'd3
  } cfgSel_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic ldBound;
    logic ldRange;
    logic ldMask;
    logic cmpEn;
  } winStrobe_t;

endpackage

// File: rtl/winMatchCtrl.sv
module winMatchCtrl
  import winMatch_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic       ctrlBit,
  output winStrobe_t strobes
);

  logic enReg;

  always_ff @(posedge clk) begin
    if (!rstN)
      enReg <= 1'b0;
    else if (cfgWrEn && cfgSel == SEL_CTRL)
      enReg <= ctrlBit;
  end

  always_comb begin
    strobes.ldBound = cfgWrEn && (cfgSel == SEL_BOUND);
    strobes.ldRange = cfgWrEn && (cfgSel == SEL_RANGE);
    strobes.ldMask  = cfgWrEn && (cfgSel == SEL_MASK);
    strobes.cmpEn   = enReg;
  end

endmodule

// File: rtl/winMatchPath.sv
module winMatchPath
  import winMatch_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  winStrobe_t   strobes,
  input  logic [W-1:0] cfgData,
  input  logic [W-1:0] obsValue,
  output logic         hit
);

  localparam int WX = W + 1;

  logic [W-1:0]  boundReg, rangeReg, maskReg;
  logic [W-1:0]  masked;
  logic [WX-1:0] maskedX, lowX, highX;
  logic          inWin, hitNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      boundReg <= '0;
      rangeReg <= '0;
      maskReg  <= '1;
    end else begin
      if (strobes.ldBound) boundReg <= cfgData;
      if (strobes.ldRange) rangeReg <= cfgData;
      if (strobes.ldMask)  maskReg  <= cfgData;
    end
  end

  always_comb begin
    masked  = obsValue & maskReg;
    maskedX = {1'b0, masked};
    lowX    = {1'b0, boundReg};
    highX   = lowX + {1'b0, rangeReg};
    inWin   = (maskedX >= lowX) && (maskedX <= highX);
    hitNext = strobes.cmpEn && inWin;
  end

  generate
    if (REG_OUT) begin : g_regOut
      logic hitQ;
      always_ff @(posedge clk) begin
        if (!rstN) hitQ <= 1'b0;
        else       hitQ <= hitNext;
      end
      assign hit = hitQ;
    end else begin : g_combOut
      assign hit = hitNext;
    end
  endgenerate

endmodule

// File: rtl/winMatch.sv
module winMatch
  import winMatch_pkg::*;
#(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [1:0]   cfgSel,
  input  logic [W-1:0] cfgData,
  input  logic [W-1:0] obsValue,
  output logic         hit
);

  winStrobe_t strobes;

  winMatchCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWrEn (cfgWrEn),
    .cfgSel  (cfgSel),
    .ctrlBit (cfgData[0]),
    .strobes (strobes)
  );

  winMatchPath #(.W(W), .REG_OUT(REG_OUT)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .cfgData  (cfgData),
    .obsValue (obsValue),
    .hit      (hit)
  );

endmodule

// File: rtl/winMatchChecker.sv
module winMatchChecker #(
  parameter int W       = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rstN,
  input logic         cfgWrEn,
  input logic [1:0]   cfgSel,
  input logic [W-1:0] cfgData,
  input logic [W-1:0] obsValue,
  input logic         hit
);

  logic [W-1:0] bSh, rSh, mSh;
  logic         enSh;
  logic [W:0]   mX, loX, hiX;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bSh <= '0; rSh <= '0; mSh <= '1; enSh <= 1'b0;
    end else if (cfgWrEn) begin
      case (cfgSel)
        2'd0: bSh <= cfgData;
        2'd1: rSh <= cfgData;
        2'd2: mSh <= cfgData;
        default: enSh <= cfgData[0];
      endcase
    end
  end

  assign mX  = {1'b0, obsValue & mSh};
  assign loX = {1'b0, bSh};
  assign hiX = {1'b0, bSh} + {1'b0, rSh};

  generate
    if (REG_OUT) begin : g_chk
      AST_RESET_CLEAR: assert property (@(posedge clk) !rstN |=> !hit); // R8
      AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
        !enSh |=> !hit); // R7
      AST_BELOW_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        (mX < loX) |=> !hit); // R2
      AST_ABOVE_TOP: assert property (@(posedge clk) disable iff (!rstN)
        (mX > hiX) |=> !hit); // R3
      AST_EXACT_ZERO_RANGE: assert property (@(posedge clk) disable iff (!rstN)
        (enSh && rSh == '0 && mX == loX) |=> hit); // R4
      AST_INSIDE_HITS: assert property (@(posedge clk) disable iff (!rstN)
        (enSh && mX >= loX && mX <= hiX) |=> hit); // R9
    end
  endgenerate

endmodule

bind winMatch winMatchChecker #(.W(W), .REG_OUT(REG_OUT)) u_winMatchChk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
  .cfgData(cfgData), .obsValue(obsValue), .hit(hit)
);

// File: tb/winMatch_bench.sv
`timescale 1ns/1ps
module winMatch_bench;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgWrEn = 1'b0;
  logic [1:0]   cfgSel = 2'd0;
  logic [W-1:0] cfgData = '0;
  logic [W-1:0] obsValue = '0;
  logic         hit;

  int    total = 0;
  int    bad = 0;
  string curReq = "R8";
  bit    done = 1'b0;

  always #2 clk = ~clk;

  winMatch #(.W(W), .REG_OUT(1'b1)) u_winMatch (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgData(cfgData), .obsValue(obsValue), .hit(hit)
  );

  // Behavioural reference: configuration as integers, output one edge late
  longint unsigned mBound, mRange, mMask;
  bit              mEn, expHit;

  always @(posedge clk) begin
    if (!rstN) begin
      mBound = 0; mRange = 0; mMask = 64'hFFFF_FFFF; mEn = 0; expHit <= 1'b0;
    end else begin
      longint unsigned mv;
      mv = longint'(obsValue) & mMask;
      expHit <= mEn && (mv >= mBound) && (mv <= mBound + mRange);
      if (cfgWrEn) begin
        if (cfgSel == 2'd0) mBound = cfgData;
        else if (cfgSel == 2'd1) mRange = cfgData;
        else if (cfgSel == 2'd2) mMask = cfgData;
        else mEn = cfgData[0];
      end
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (hit !== expHit) begin
        bad++;
        $display("FAIL %s model: hit=%0b expected=%0b", curReq, hit, expHit);
      end
    end
  end

  task automatic check(input bit exp, input string req);
    total++;
    if (hit !== exp) begin
      bad++;
      $display("FAIL %s: hit=%0b expected=%0b obs=%h", req, hit, exp, obsValue);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    cfgWrEn = 1'b1; cfgSel = sel; cfgData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic probe(input logic [W-1:0] v, input bit exp, input string req);
    curReq = req;
    obsValue = v;
    @(negedge clk);
    check(exp, req);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: hit=%0b expected=done", hit);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b0, "R8");              // reset state
    rstN = 1'b1;
    @(negedge clk);

    // R7: enable still 0, window around 0 would match
    probe(32'h0, 1'b0, "R7");

    // R10 + R5: worked example
    wr(2'd2, 32'h20E);
    wr(2'd0, 32'h200);
    wr(2'd1, 32'hF);
    wr(2'd3, 32'h1);
    probe(32'h200,  1'b1, "R5");
    probe(32'h20F,  1'b1, "R5");
    probe(32'h1F0,  1'b0, "R5");
    probe(32'h300,  1'b1, "R1");   // bit 8 masked off
    probe(32'h1200, 1'b1, "R1");   // bit 12 masked off
    probe(32'h201,  1'b1, "R1");   // bit 0 masked off

    // R2/R3 edges with full mask
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd0, 32'h1000);
    wr(2'd1, 32'h10);
    probe(32'hFFF,  1'b0, "R2");
    probe(32'h1000, 1'b1, "R2");
    probe(32'h1010, 1'b1, "R3");
    probe(32'h1011, 1'b0, "R3");

    // R8: output does not move before the edge
    obsValue = 32'h1005;
    #1 check(1'b0, "R8");
    @(negedge clk);
    check(1'b1, "R8");

    // R4: exact match
    wr(2'd1, 32'h0);
    wr(2'd0, 32'h55);
    probe(32'h55, 1'b1, "R4");
    probe(32'h56, 1'b0, "R4");
    probe(32'h54, 1'b0, "R4");

    // R9: write and compare on the same edge use the old bound
    curReq = "R9";
    obsValue = 32'h77;
    cfgWrEn = 1'b1; cfgSel = 2'd0; cfgData = 32'h77;
    @(negedge clk);
    cfgWrEn = 1'b0;
    check(1'b0, "R9");
    @(negedge clk);
    check(1'b1, "R9");

    // R10: strobe low means no write
    cfgSel = 2'd0; cfgData = 32'h99;
    probe(32'h77, 1'b1, "R10");

    // R6: no wrap at the top
    wr(2'd0, 32'hFFFF_FFF0);
    wr(2'd1, 32'h20);
    probe(32'hFFFF_FFFF, 1'b1, "R6");
    probe(32'h0000_0005, 1'b0, "R6");
    probe(32'hFFFF_FFEF, 1'b0, "R6");

    // R7: disable with a value in the window
    wr(2'd3, 32'h0);
    probe(32'hFFFF_FFF8, 1'b0, "R7");
    probe(32'hFFFF_FFFF, 1'b0, "R7");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule